// File: doc/BRIEF.md
# Core Power-State Sequencer

This block moves a processor core between four power levels: full-on, doze, nap and sleep. Software selects the low-power level ahead of time on a three-bit mode field, then invokes it later by raising a separate power-enable input. Doze takes effect at once and only stops the execution clocks. Nap and sleep first wait for the bus interface to report that no bus operation is outstanding. They then raise a quiesce request to system logic and wait for the acknowledge. Sleep also waits out a settling delay of `ENTRY_DLY` clocks after the acknowledge before it stops every clock.

Any of five wake sources brings the core back to full power: external interrupt, system-management interrupt, machine check, soft reset, or the asynchronous hard reset. A wake cancels an entry that is still pending, and it also overrides a new power-enable request.

The FSM has seven states:
- `PM_ON` (full-on)
- `PM_DOZE`
- `PM_DRAIN` (waiting for bus idle)
- `PM_HANDSHAKE` (request raised, waiting for acknowledge)
- `PM_SETTLE` (sleep delay)
- `PM_NAP`
- `PM_SLEEP`

The transitions are:
- **Entry:** `PM_ON`→`PM_DOZE`, or `PM_ON`→`PM_DRAIN`, on power-enable with a valid mode.
- **Bus idle:** `PM_DRAIN`→`PM_HANDSHAKE`.
- **Acknowledge:** `PM_HANDSHAKE`→`PM_NAP` for nap, or `PM_HANDSHAKE`→`PM_SETTLE` for sleep.
- **Delay done:** `PM_SETTLE`→`PM_SLEEP`.
- **Wake:** any state→`PM_ON`.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While hard reset (`rst_n` low, asynchronous) is applied and after it is released, `qreq` is 0, all three clock enables are 1 and `pwr_level` is 0 (full-on). Asserting `rst_n` low from any state restores this at once.
- R2: `mode_sel` bit 0 selects doze, bit 1 nap and bit 2 sleep. A mode field by itself does nothing until `pow_en` is sampled high. `pow_en` with exactly one mode bit set starts entry into that level.
- R3: `pow_en` with no mode bit set, or with more than one set, is ignored: `qreq` stays 0 and `pwr_level` stays 0 even with the bus idle.
- R4: Doze is reached in the cycle after `pow_en` is sampled. In doze, `exec_clk_en` is 0, `bus_clk_en` and `tmr_clk_en` are 1, `pwr_level` is 1, and `qreq` is never raised.
- R5: For nap or sleep, `qreq` stays 0 and all clocks stay enabled for as long as `bus_idle` is sampled low.
- R6: `qreq` rises in the cycle after `bus_idle` is first sampled high during a nap or sleep entry, and it holds until the acknowledge is taken.
- R7: Nap is reached in the cycle after `qack` is sampled high. In nap, exec and bus clocks are off, the timer clock is on, `pwr_level` is 2 and `qreq` remains 1.
- R8: For sleep, all clocks stay enabled for `ENTRY_DLY` cycles after `qack` is sampled. After that, all three enables are 0, `pwr_level` is 3 and `qreq` remains 1.
- R9: A sampled wake (`irq_ext`, `irq_smi`, `irq_mchk` or `soft_rst`) in any state makes `qreq` 0, all enables 1 and `pwr_level` 0 in the next cycle. This includes states where entry is still pending.
- R10: A wake sampled together with `pow_en` wins: the controller stays in full-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| mode_sel | input | 3 | Preselected low-power level: bit0 doze, bit1 nap, bit2 sleep |
| pow_en | input | 1 | Invokes the preselected level |
| bus_idle | input | 1 | No outstanding bus operation |
| qack | input | 1 | Quiesce acknowledge from system logic |
| irq_ext | input | 1 | External interrupt wake |
| irq_smi | input | 1 | System-management interrupt wake |
| irq_mchk | input | 1 | Machine-check wake |
| soft_rst | input | 1 | Soft reset wake |
| qreq | output | 1 | Quiesce request to system logic |
| exec_clk_en | output | 1 | Execution-unit clock enable |
| bus_clk_en | output | 1 | Bus-interface clock enable |
| tmr_clk_en | output | 1 | Timer/remaining clock enable |
| pwr_level | output | 2 | Current level: 0 full-on, 1 doze, 2 nap, 3 sleep |

## Verification
The bench builds the block with `ENTRY_DLY` set to 3 rather than the default 8. This keeps every sleep entry short enough that the random loop reaches the settling window many times. It also allows a directed wake to land in the middle of that window. Random runs vary the bus-drain wait, the acknowledge latency, the wake source and the chosen level, including empty and multi-bit mode fields. A full entry can therefore be interrupted at each of its stages.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_ON,
        PM_DOZE,
        PM_DRAIN,
        PM_HANDSHAKE,
        PM_SETTLE,
        PM_NAP,
        PM_SLEEP
    } pm_state_e;

    typedef enum logic [1:0] {
        LVL_FULL  = 2'd0,
        LVL_DOZE  = 2'd1,
        LVL_NAP   = 2'd2,
        LVL_SLEEP = 2'd3
    } pm_level_e;

endpackage

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
    import pwr_mode_pkg::*;
(
    input  logic [2:0] mode_sel,
    output logic       sel_valid,
    output pm_level_e  sel_level
);

    // Exactly one bit must be set; anything else is not a request
    always_comb begin
        sel_valid = 1'b1;
        sel_level = LVL_FULL;
        case (mode_sel)
            3'b001:  sel_level = LVL_DOZE;
            3'b010:  sel_level = LVL_NAP;
            3'b100:  sel_level = LVL_SLEEP;
            default: sel_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/pm_entry_timer.sv
module pm_entry_timer #(
    parameter int ENTRY_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (ENTRY_DLY < 2) ? 1 : $clog2(ENTRY_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(ENTRY_DLY - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end

    // Counter never runs past the programmed delay (R8)
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/pm_clk_map.sv
module pm_clk_map
    import pwr_mode_pkg::*;
(
    input  pm_state_e st,
    output logic      exec_en,
    output logic      bus_en,
    output logic      tmr_en,
    output pm_level_e level
);

    always_comb begin
        exec_en = 1'b1;
        bus_en  = 1'b1;
        tmr_en  = 1'b1;
        level   = LVL_FULL;
        unique case (st)
            PM_DOZE: begin
                exec_en = 1'b0;
                level   = LVL_DOZE;
            end
            PM_NAP: begin
                exec_en = 1'b0;
                bus_en  = 1'b0;
                level   = LVL_NAP;
            end
            PM_SLEEP: begin
                exec_en = 1'b0;
                bus_en  = 1'b0;
                tmr_en  = 1'b0;
                level   = LVL_SLEEP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int ENTRY_DLY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       pow_en,
    input  logic       bus_idle,
    input  logic       qack,
    input  logic       irq_ext,
    input  logic       irq_smi,
    input  logic       irq_mchk,
    input  logic       soft_rst,
    output logic       qreq,
    output logic       exec_clk_en,
    output logic       bus_clk_en,
    output logic       tmr_clk_en,
    output logic [1:0] pwr_level
);

    pm_state_e st_q, st_d;
    pm_level_e tgt_q;
    pm_level_e sel_level;
    pm_level_e map_level;
    logic      sel_valid;
    logic      dly_done;
    logic      wake;

    assign wake = irq_ext | irq_smi | irq_mchk | soft_rst;

    pm_mode_decode u_dec (
        .mode_sel  (mode_sel),
        .sel_valid (sel_valid),
        .sel_level (sel_level)
    );

    pm_entry_timer #(.ENTRY_DLY(ENTRY_DLY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q == PM_SETTLE),
        .done  (dly_done)
    );

    pm_clk_map u_map (
        .st      (st_q),
        .exec_en (exec_clk_en),
        .bus_en  (bus_clk_en),
        .tmr_en  (tmr_clk_en),
        .level   (map_level)
    );

    // Next-state logic: a wake always wins
    always_comb begin
        st_d = st_q;
        if (wake) begin
            st_d = PM_ON;
        end else begin
            unique case (st_q)
                PM_ON:
                    if (pow_en && sel_valid)
                        st_d = (sel_level == LVL_DOZE) ? PM_DOZE : PM_DRAIN;
                PM_DOZE:      st_d = PM_DOZE;
                PM_DRAIN:
                    if (bus_idle) st_d = PM_HANDSHAKE;
                PM_HANDSHAKE:
                    if (qack) st_d = (tgt_q == LVL_SLEEP) ? PM_SETTLE : PM_NAP;
                PM_SETTLE:
                    if (dly_done) st_d = PM_SLEEP;
                PM_NAP:       st_d = PM_NAP;
                PM_SLEEP:     st_d = PM_SLEEP;
                default:      st_d = PM_ON;
            endcase
        end
    end

    // State register and latched target level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PM_ON;
            tgt_q <= LVL_FULL;
        end else begin
            st_q <= st_d;
            if (st_q == PM_ON && st_d == PM_DRAIN)
                tgt_q <= sel_level;
        end
    end

    // Outputs
    always_comb begin
        qreq      = (st_q == PM_HANDSHAKE) || (st_q == PM_SETTLE) ||
                    (st_q == PM_NAP) || (st_q == PM_SLEEP);
        pwr_level = map_level;
    end

    p_reset_full_r1: assert property (@(posedge clk)
        !rst_n |-> (!qreq && exec_clk_en && bus_clk_en && tmr_clk_en));

    p_bad_cfg_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_ON && pow_en && $countones(mode_sel) != 1)
        |=> (st_q == PM_ON));

    p_doze_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_level == LVL_DOZE) |-> !qreq);

    p_req_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qreq) |-> $past(bus_idle));

    p_nap_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_level == LVL_NAP) |-> $past(qack));

    p_sleep_after_dly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_level == LVL_SLEEP) |-> $past(dly_done));

    p_sleep_all_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_level == LVL_SLEEP) |-> (!exec_clk_en && !bus_clk_en && !tmr_clk_en));

    p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!qreq && exec_clk_en && bus_clk_en && tmr_clk_en
                  && pwr_level == LVL_FULL));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DLY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = '0;
    logic       pow_en = 1'b0, bus_idle = 1'b0, qack = 1'b0;
    logic       irq_ext = 1'b0, irq_smi = 1'b0, irq_mchk = 1'b0, soft_rst = 1'b0;
    logic       qreq, exec_clk_en, bus_clk_en, tmr_clk_en;
    logic [1:0] pwr_level;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.ENTRY_DLY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pow_en(pow_en),
        .bus_idle(bus_idle), .qack(qack), .irq_ext(irq_ext), .irq_smi(irq_smi),
        .irq_mchk(irq_mchk), .soft_rst(soft_rst), .qreq(qreq),
        .exec_clk_en(exec_clk_en), .bus_clk_en(bus_clk_en),
        .tmr_clk_en(tmr_clk_en), .pwr_level(pwr_level)
    );

    // Expected {qreq, exec, bus, tmr, level} for a level and request state
    function automatic logic [5:0] expv(input logic q, input int lvl);
        return {q, lvl == 0, lvl < 2, lvl < 3, 2'(lvl)};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic q, input int lvl);
        logic [5:0] act, exp;
        act = {qreq, exec_clk_en, bus_clk_en, tmr_clk_en, pwr_level};
        exp = expv(q, lvl);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_wake(input int src, input logic v);
        case (src)
            0: irq_ext = v;
            1: irq_smi = v;
            2: irq_mchk = v;
            default: soft_rst = v;
        endcase
    endtask

    task automatic do_wake(input int src);
        pow_en = 0; qack = 0; bus_idle = 0;
        set_wake(src, 1'b1);
        step();
        chk("R9 wake", 0, 0);
        set_wake(src, 1'b0);
        step();
        chk("R9 stay on", 0, 0);
    endtask

    // kind: 0 doze, 1 nap, 2 sleep, 3 invalid field
    task automatic scenario(input int kind, input int dw, input int qw, input int w);
        case (kind)
            0: mode_sel = 3'b001;
            1: mode_sel = 3'b010;
            2: mode_sel = 3'b100;
            default: mode_sel = ($urandom % 2) ? 3'b000 : 3'b110;
        endcase
        bus_idle = (kind == 3);
        qack = 0;
        pow_en = 1;
        step();
        if (kind == 3) begin
            step();
            chk("R3 invalid mode ignored", 0, 0);
            pow_en = 0; bus_idle = 0;
            return;
        end
        if (kind == 0) begin
            chk("R4 doze entry", 0, 1);
            step();
            chk("R4 doze held", 0, 1);
            do_wake(w);
            return;
        end
        chk("R5 drain start", 0, 0);
        for (int i = 0; i < dw; i++) begin
            step();
            chk("R5 wait bus idle", 0, 0);
        end
        bus_idle = 1;
        step();
        chk("R6 qreq raised", 1, 0);
        for (int i = 0; i < qw; i++) begin
            step();
            chk("R6 qreq held", 1, 0);
        end
        qack = 1;
        step();
        if (kind == 1) begin
            chk("R7 nap entry", 1, 2);
        end else begin
            chk("R8 settle start", 1, 0);
            for (int i = 0; i < DLY - 1; i++) begin
                step();
                chk("R8 settle", 1, 0);
            end
            step();
            chk("R8 sleep entry", 1, 3);
        end
        do_wake(w);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0603));
        #2;
        chk("R1 in reset", 0, 0);
        step(); step();
        rst_n = 1;
        step();
        chk("R1 after reset", 0, 0);

        // R2: mode field alone does nothing
        mode_sel = 3'b100; bus_idle = 1;
        step(); step(); step();
        chk("R2 no pow_en", 0, 0);
        // R2: entry latency with bus already idle: drain then request
        pow_en = 1;
        step();
        chk("R2 drain", 0, 0);
        step();
        chk("R2 request", 1, 0);
        do_wake(0);

        // R10: wake together with pow_en
        mode_sel = 3'b001; pow_en = 1; irq_smi = 1;
        step();
        chk("R10 wake beats entry", 0, 0);
        irq_smi = 0; pow_en = 0;
        step();

        // R9: wake in the middle of the sleep settle window
        mode_sel = 3'b100; bus_idle = 1; pow_en = 1;
        step(); step();
        qack = 1;
        step();
        step();
        chk("R9 settle pending", 1, 0);
        do_wake(2);

        // R11-style hard reset from sleep (R1)
        mode_sel = 3'b100; bus_idle = 1; pow_en = 1;
        step(); step();
        qack = 1;
        step();
        repeat (DLY) step();
        chk("R8 sleep before reset", 1, 3);
        #3;
        rst_n = 0;
        #1;
        chk("R1 async reset", 0, 0);
        pow_en = 0; qack = 0; bus_idle = 0;
        step();
        rst_n = 1;
        step();
        chk("R1 reset release", 0, 0);

        // Random mix
        for (int it = 0; it < 60; it++)
            scenario($urandom % 4, $urandom % 4, $urandom % 3, $urandom % 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule